// File: doc/BRIEF.md
# Bit-Serial Odd-Even Transposition Sorter

This block sorts a small, fixed-size set of unsigned words into ascending order. The words are loaded in parallel into a primary storage bank. A start pulse then launches a sequence of sorting steps. In each step every word is shifted out one bit per clock, most significant bit first, through a row of bit-serial compare-and-swap cells. The results are shifted into the other storage bank. Each cell decides on the first bit position where its two inputs differ, then keeps that decision for the rest of the word.

The cells pair neighbouring words in two alternating patterns. Even-indexed steps pair (0,1), (2,3) and so on. Odd-indexed steps pair (1,2), (3,4) and so on, and the two end words pass through unchanged. The two banks swap roles after every step. After exactly as many steps as there are words, the array is sorted with the smallest value at index 0. A done flag then rises and the read port presents the sorted bank.

Every step costs one clock per bit plus the fixed pipeline delay of the compare row. The total sort time is therefore linear in the word count and known exactly in advance.

Top module: `oets_sorter`

## Requirements
- R1: A load pulse while idle stores the N words of the load bus (word i in bits [i*W +: W]). From the next cycle the read port shows exactly those words at the same positions, and done is low.
- R2: A start pulse while idle and without a simultaneous load makes busy high from the next cycle.
- R3: When done rises, the read port holds the loaded words in ascending unsigned order, with word 0 the smallest.
- R4: The sorted result is a permutation of the loaded words, so duplicate values are all kept.
- R5: Busy stays high for exactly N*(W+LAT) cycles, where W is the word width and LAT the compare pipeline delay. Done rises on the cycle busy falls.
- R6: A start pulse while busy has no effect: the sort length and the result are unchanged.
- R7: A load pulse while busy has no effect: the result is the sort of the words loaded before start.
- R8: Done and busy are never high together. Done stays high while idle until the next load or start.
- R9: After reset, busy and done are low and the read port reads all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Load pulse, taken only while idle |
| load_data_i | input | N*W | Words to load, word i at [i*W +: W] |
| start_i | input | 1 | Start pulse, taken only while idle |
| busy_o | output | 1 | High while the sort steps run |
| done_o | output | 1 | High after a finished sort until the next load or start |
| rd_data_o | output | N*W | Current result bank, word i at [i*W +: W] |

## Verification
A cell that fails to lock its decision would shift wrong low-order bits into some words. The read port would then show values that appear nowhere in the input, so the permutation check catches it the moment done rises. A wrong pairing parity or a wrong step count leaves inversions, and these are visible as unordered neighbours at done. An off-by-one in the step or bit counters moves the done edge away from N*(W+LAT) cycles, and the cycle count catches that within a single sort. Duplicate-heavy, all-equal, reversed and extreme-value arrays exercise the point where a cell decides, including the case where it never decides.

// File: rtl/oets_pkg.sv
package oets_pkg;
   typedef enum logic [0:0] {
      PH_IDLE = 1'b0,
      PH_RUN  = 1'b1
   } phase_t;
endpackage

// File: rtl/oets_cswap_cell.sv
module oets_cswap_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic first_i,
   input  logic a_i,
   input  logic b_i,
   output logic lo_o,
   output logic hi_o
);
   logic dec_q, swp_q;
   logic dec_now, swp_now;

   always_comb begin
      dec_now = first_i ? 1'b0 : dec_q;
      swp_now = first_i ? 1'b0 : swp_q;
      if (!dec_now && (a_i != b_i)) begin
         dec_now = 1'b1;
         swp_now = a_i;
      end
      lo_o = swp_now ? b_i : a_i;
      hi_o = swp_now ? a_i : b_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dec_q <= 1'b0;
         swp_q <= 1'b0;
      end else begin
         dec_q <= dec_now;
         swp_q <= swp_now;
      end
   end

   AST_DECISION_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_q && !first_i) |=> (swp_q == $past(swp_q))); // R4
endmodule

// File: rtl/oets_delay_line.sv
module oets_delay_line #(
   parameter int WD  = 8,
   parameter int LAT = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [WD-1:0] d_i,
   output logic [WD-1:0] q_o
);
   initial begin
      if (LAT < 1) $error("delay line needs LAT >= 1");
   end

   logic [WD-1:0] st [LAT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st[0] <= '0;
      else        st[0] <= d_i;
   end

   for (genvar k = 1; k < LAT; k++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) st[k] <= '0;
         else        st[k] <= st[k-1];
      end
   end

   assign q_o = st[LAT-1];
endmodule

// File: rtl/oets_step_ctrl.sv
module oets_step_ctrl
   import oets_pkg::*;
#(
   parameter int N   = 8,
   parameter int W   = 32,
   parameter int LAT = 6,
   localparam int STEP_LEN = W + LAT,
   localparam int CW = $clog2(STEP_LEN),
   localparam int SW = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic          load_i,
   output logic          busy_o,
   output logic          done_o,
   output logic          bank_o,
   output logic          odd_o,
   output logic [CW-1:0] cyc_o
);
   phase_t        ph_q;
   logic [SW-1:0] step_q;
   logic [CW-1:0] cyc_q;
   logic          bank_q, done_q;
   logic          go, last_cyc, last_step;

   assign go        = (ph_q == PH_IDLE) && start_i && !load_i;
   assign last_cyc  = (cyc_q == CW'(STEP_LEN - 1));
   assign last_step = (step_q == SW'(N - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= PH_IDLE;
         step_q <= '0;
         cyc_q  <= '0;
         bank_q <= 1'b0;
         done_q <= 1'b0;
      end else if (ph_q == PH_IDLE) begin
         if (load_i) begin
            bank_q <= 1'b0;
            done_q <= 1'b0;
         end else if (go) begin
            ph_q   <= PH_RUN;
            step_q <= '0;
            cyc_q  <= '0;
            done_q <= 1'b0;
         end
      end else begin
         if (last_cyc) begin
            cyc_q  <= '0;
            bank_q <= ~bank_q;
            if (last_step) begin
               ph_q   <= PH_IDLE;
               done_q <= 1'b1;
            end else begin
               step_q <= step_q + SW'(1);
            end
         end else begin
            cyc_q <= cyc_q + CW'(1);
         end
      end
   end

   assign busy_o = (ph_q == PH_RUN);
   assign done_o = done_q;
   assign bank_o = bank_q;
   assign odd_o  = step_q[0];
   assign cyc_o  = cyc_q;

   AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && start_i && !load_i) |=> busy_o); // R2
   AST_DONE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy_o && done_o)); // R8
   AST_DONE_FROM_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> $fell(busy_o)); // R5
   AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> (int'(step_q) < N && int'(cyc_q) < STEP_LEN)); // R5
   AST_DONE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start_i && !load_i) |=> done_o); // R8
endmodule

// File: rtl/oets_sorter.sv
module oets_sorter #(
   parameter int N   = 8,
   parameter int W   = 32,
   parameter int LAT = 6,
   localparam int STEP_LEN = W + LAT,
   localparam int CW = $clog2(STEP_LEN),
   localparam int NC = N / 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load_i,
   input  logic [N*W-1:0] load_data_i,
   input  logic           start_i,
   output logic           busy_o,
   output logic           done_o,
   output logic [N*W-1:0] rd_data_o
);
   initial begin
      if (N < 2 || (N % 2) != 0) $error("N must be even and at least 2");
      if (W < 2) $error("W must be at least 2");
      if (LAT < 1) $error("LAT must be at least 1");
   end

   logic          bank, odd;
   logic [CW-1:0] cyc;
   logic [W-1:0]  mem [2][N];
   logic [N-1:0]  src_bits, net_bits, dly_bits;
   logic [NC-1:0] c_a, c_b, c_lo, c_hi;
   logic          feed, first, capture;

   oets_step_ctrl #(.N(N), .W(W), .LAT(LAT)) i_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .load_i  (load_i),
      .busy_o  (busy_o),
      .done_o  (done_o),
      .bank_o  (bank),
      .odd_o   (odd),
      .cyc_o   (cyc)
   );

   assign feed    = busy_o && (int'(cyc) < W);
   assign first   = busy_o && (cyc == '0);
   assign capture = busy_o && (int'(cyc) >= LAT);

   always_comb begin
      for (int i = 0; i < N; i++) begin
         src_bits[i] = feed ? mem[bank][i][W-1-int'(cyc)] : 1'b0;
      end
   end

   for (genvar j = 0; j < NC; j++) begin : g_cell
      if (j < NC - 1) begin : g_mid
         assign c_a[j] = odd ? src_bits[2*j+1] : src_bits[2*j];
         assign c_b[j] = odd ? src_bits[2*j+2] : src_bits[2*j+1];
      end else begin : g_end
         assign c_a[j] = odd ? 1'b0 : src_bits[2*j];
         assign c_b[j] = odd ? 1'b0 : src_bits[2*j+1];
      end
      oets_cswap_cell i_cell (
         .clk     (clk),
         .rst_n   (rst_n),
         .first_i (first),
         .a_i     (c_a[j]),
         .b_i     (c_b[j]),
         .lo_o    (c_lo[j]),
         .hi_o    (c_hi[j])
      );
   end

   always_comb begin
      net_bits = src_bits;
      for (int j = 0; j < NC; j++) begin
         if (!odd) begin
            net_bits[2*j]   = c_lo[j];
            net_bits[2*j+1] = c_hi[j];
         end else if (j < NC - 1) begin
            net_bits[2*j+1] = c_lo[j];
            net_bits[2*j+2] = c_hi[j];
         end
      end
   end

   oets_delay_line #(.WD(N), .LAT(LAT)) i_dly (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (net_bits),
      .q_o   (dly_bits)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int b = 0; b < 2; b++)
            for (int i = 0; i < N; i++) mem[b][i] <= '0;
      end else if (!busy_o && load_i) begin
         for (int i = 0; i < N; i++) mem[0][i] <= load_data_i[i*W +: W];
      end else if (capture) begin
         for (int i = 0; i < N; i++)
            mem[~bank][i] <= {mem[~bank][i][W-2:0], dly_bits[i]};
      end
   end

   always_comb begin
      for (int i = 0; i < N; i++) rd_data_o[i*W +: W] = mem[bank][i];
   end

   function automatic logic ordered(input logic [N*W-1:0] v);
      ordered = 1'b1;
      for (int i = 0; i + 1 < N; i++)
         if (v[i*W +: W] > v[(i+1)*W +: W]) ordered = 1'b0;
   endfunction

   AST_RESULT_ORDERED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> ordered(rd_data_o)); // R3
   AST_IDLE_BANK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !load_i && !start_i) |=> $stable(rd_data_o)); // R8
endmodule

// File: tb/test_oets_sorter.sv
module test_oets_sorter;
   localparam int N   = 8;
   localparam int W   = 32;
   localparam int LAT = 6;
   localparam int RUN = N * (W + LAT);

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           load_i = 1'b0;
   logic [N*W-1:0] load_data_i = '0;
   logic           start_i = 1'b0;
   logic           busy_o, done_o;
   logic [N*W-1:0] rd_data_o;

   int n_chk = 0;
   int n_fail = 0;
   logic [W-1:0] cur [N];
   logic [W-1:0] alt [N];
   logic [W-1:0] exp_s [N];

   always #10 clk = ~clk;

   oets_sorter #(.N(N), .W(W), .LAT(LAT)) i_oets_sorter (
      .clk(clk), .rst_n(rst_n), .load_i(load_i), .load_data_i(load_data_i),
      .start_i(start_i), .busy_o(busy_o), .done_o(done_o), .rd_data_o(rd_data_o)
   );

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic make_expected();
      logic [W-1:0] t;
      for (int i = 0; i < N; i++) exp_s[i] = cur[i];
      for (int p = 0; p < N; p++)
         for (int i = 0; i + 1 < N; i++)
            if (exp_s[i] > exp_s[i+1]) begin
               t = exp_s[i]; exp_s[i] = exp_s[i+1]; exp_s[i+1] = t;
            end
   endtask

   // disturb: 0 none, 1 start pulse mid-run (R6), 2 load pulse mid-run (R7)
   task automatic run_sort(input int disturb);
      int cnt;
      @(negedge clk);
      for (int i = 0; i < N; i++) load_data_i[i*W +: W] = cur[i];
      load_i = 1'b1;
      @(negedge clk);
      load_i = 1'b0;
      for (int i = 0; i < N; i++) chk("R1 load visible", rd_data_o[i*W +: W], cur[i]);
      chk("R1 done low after load", W'(done_o), '0);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk("R2 busy after start", W'(busy_o), W'(1));
      cnt = 0;
      while (busy_o && cnt < RUN + 50) begin
         cnt++;
         if (cnt == 40 && disturb == 1) start_i = 1'b1;
         if (cnt == 60 && disturb == 2) begin
            for (int i = 0; i < N; i++) load_data_i[i*W +: W] = alt[i];
            load_i = 1'b1;
         end
         @(negedge clk);
         start_i = 1'b0;
         load_i = 1'b0;
      end
      chk(disturb == 1 ? "R6 run length" : "R5 run length", W'(cnt), W'(RUN));
      chk("R5 done at end", W'(done_o), W'(1));
      make_expected();
      for (int i = 0; i < N; i++)
         chk(disturb == 2 ? "R7 result" : "R3 R4 sorted word", rd_data_o[i*W +: W], exp_s[i]);
      repeat (3) @(negedge clk);
      chk("R8 done held", W'(done_o), W'(1));
      chk("R8 busy low", W'(busy_o), '0);
   endtask

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      chk("R9 busy reset", W'(busy_o), '0);
      chk("R9 done reset", W'(done_o), '0);
      for (int i = 0; i < N; i++) chk("R9 read zero", rd_data_o[i*W +: W], '0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < N; i++) cur[i] = W'(N - i);             // reversed
      run_sort(0);
      for (int i = 0; i < N; i++) cur[i] = W'(i * 3);             // already sorted
      run_sort(0);
      for (int i = 0; i < N; i++) cur[i] = 32'h5A5A_0F0F;         // all equal
      run_sort(0);
      for (int i = 0; i < N; i++) cur[i] = (i % 2) ? 32'hFFFF_FFFF : 32'h0;
      run_sort(0);
      for (int i = 0; i < N; i++) cur[i] = W'($urandom_range(3)) << 30 | W'($urandom_range(2));
      run_sort(0);                                                 // heavy duplicates
      for (int r = 0; r < 6; r++) begin
         for (int i = 0; i < N; i++) cur[i] = $urandom();
         run_sort(0);
      end
      for (int i = 0; i < N; i++) cur[i] = $urandom();
      run_sort(1);
      for (int i = 0; i < N; i++) begin
         cur[i] = $urandom();
         alt[i] = $urandom();
      end
      run_sort(2);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule